// File: doc/BRIEF.md
# Flushed-Epoch Timestamp Table

This block is a shared table kept beside the last-level cache. It holds one record per hardware thread. Each record is the newest epoch timestamp that the thread has made durable.

Persist buffers write a record when a durability fence on their thread completes. Records are therefore refreshed lazily, at fence completion, and not on every drain. Timestamps are unsigned and only grow, so the table keeps the larger of the stored and the offered value.

Before a persist buffer drains an epoch that depends on another thread's stores, it presents a query. The query names that thread and the timestamp the dependency needs. The table grants the query if the stored record has reached that timestamp, and stalls it otherwise.

Both port groups are valid/ready streams:
- An update port holds `upd_valid` with a stable thread ID and timestamp until it sees `upd_ready`.
- `upd_ready` falls only when a higher-priority update port targets the same thread in the same cycle.
- A query port holds `qry_valid` with a stable thread ID and required timestamp. `qry_ready` high is a grant; `qry_valid` high with `qry_ready` low is a stall.
- `qry_ready` is combinational, so the requester may retry every cycle with no added latency.

Top module: `gft_table`

## Requirements
- R1: While `rst_n` is low and on the first cycle after, every record reads zero. A query for any thread with required timestamp 0 is granted, and one with required timestamp 1 is stalled.
- R2: A valid query is granted (`qry_ready`=1) when the named thread's record is greater than or equal to the required timestamp. It is stalled (`qry_ready`=0) when the record is lower; for example, a record of 24 against a requirement of 25 stalls.
- R3: An accepted update (`upd_valid` and `upd_ready` both 1) whose timestamp is above the stored record replaces that record at the clock edge.
- R4: An accepted update whose timestamp is lower than or equal to the stored record leaves the record unchanged, and is still accepted.
- R5: A query and an accepted update for the same thread in the same cycle are compared against the updated value. For example, with a record of 24, an update to 25 grants a 0:25 query in that same cycle.
- R6: When several update ports target one thread in one cycle, the lowest-numbered port wins. Each losing port sees `upd_ready`=0 and its value is not written that cycle. Port 0 is never refused.
- R7: Updates from different ports to different threads in one cycle are all accepted and all written.
- R8: Query ports are independent. A query held stable stays granted once it has been granted, and a stalled query is granted as soon as its record reaches the required value.
- R9: A query port with `qry_valid`=0 drives `qry_ready`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| upd_valid | input | NUM_UPD | Update request per port |
| upd_tid | input | NUM_UPD*TID_W | Thread ID per update port, port p at bits [p*TID_W +: TID_W] |
| upd_ts | input | NUM_UPD*TS_W | Durable timestamp per update port, port p at bits [p*TS_W +: TS_W] |
| upd_ready | output | NUM_UPD | Update accepted this cycle |
| qry_valid | input | NUM_QRY | Query request per port |
| qry_tid | input | NUM_QRY*TID_W | Thread ID whose record is consulted |
| qry_ts | input | NUM_QRY*TS_W | Required timestamp |
| qry_ready | output | NUM_QRY | 1 = grant, 0 with valid = stall |

## Verification
The hardest situation to reach is a cycle in which two update ports collide on one thread while a query on that thread is also live. In that cycle the bypass must carry only the winner's value, and the loser must be neither written nor lost.

The conflict task builds that cycle directly. It drives both update ports to one thread with different timestamps and places query thresholds on each side of the two values. It then checks the record after the edge, re-offers the losing value alone, and checks that it lands.

// File: rtl/gft_pkg.sv
package gft_pkg;
  // Width of an index over n items, never below one bit.
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/gft_upd_arb.sv
module gft_upd_arb #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_UPD     = 2,
  parameter int TS_W        = 8,
  parameter int TID_W       = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_UPD-1:0]       upd_valid,
  input  logic [NUM_UPD*TID_W-1:0] upd_tid,
  input  logic [NUM_UPD*TS_W-1:0]  upd_ts,
  output logic [NUM_UPD-1:0]       upd_ready,
  output logic [NUM_THREADS-1:0]   wr_en,
  output logic [NUM_THREADS*TS_W-1:0] wr_ts
);
  // Fixed priority per thread: the lowest port index claims the write slot.
  always_comb begin
    wr_en     = '0;
    wr_ts     = '0;
    upd_ready = '1;
    for (int p = 0; p < NUM_UPD; p++) begin
      if (upd_valid[p]) begin
        for (int t = 0; t < NUM_THREADS; t++) begin
          if (upd_tid[p*TID_W +: TID_W] == TID_W'(t)) begin
            if (wr_en[t]) begin
              upd_ready[p] = 1'b0;
            end else begin
              wr_en[t]              = 1'b1;
              wr_ts[t*TS_W +: TS_W] = upd_ts[p*TS_W +: TS_W];
            end
          end
        end
      end
    end
  end

  // R6
  top_port_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_valid[0] |-> upd_ready[0]);
endmodule

// File: rtl/gft_record.sv
module gft_record #(
  parameter int TS_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [TS_W-1:0] wr_ts,
  output logic [TS_W-1:0] rec_q,
  output logic [TS_W-1:0] rec_eff
);
  // Keep the larger value; rec_eff is also the same-cycle bypass for queries.
  assign rec_eff = (wr_en && (wr_ts > rec_q)) ? wr_ts : rec_q;

  always_ff @(posedge clk) begin
    if (!rst_n) rec_q <= '0;
    else        rec_q <= rec_eff;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (rec_q == '0));
  // R3
  raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_ts > rec_q)) |=> (rec_q == $past(wr_ts)));
  // R4
  ignore_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_ts <= rec_q)) |=> $stable(rec_q));
  // R4
  never_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (rec_q >= $past(rec_q)));
endmodule

// File: rtl/gft_query.sv
module gft_query #(
  parameter int NUM_THREADS = 4,
  parameter int TS_W        = 8,
  parameter int TID_W       = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        qry_valid,
  input  logic [TID_W-1:0]            qry_tid,
  input  logic [TS_W-1:0]             qry_ts,
  input  logic [NUM_THREADS*TS_W-1:0] rec_eff_all,
  output logic                        qry_ready
);
  logic [TS_W-1:0] sel_ts;

  always_comb begin
    sel_ts = '0;
    for (int t = 0; t < NUM_THREADS; t++) begin
      if (qry_tid == TID_W'(t)) sel_ts = rec_eff_all[t*TS_W +: TS_W];
    end
  end

  assign qry_ready = qry_valid && (sel_ts >= qry_ts);

  // R9
  idle_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !qry_valid |-> !qry_ready);
  // R8
  grant_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && qry_valid && $past(qry_valid) && $past(qry_ready)
     && $stable(qry_tid) && $stable(qry_ts)) |-> qry_ready);
endmodule

// File: rtl/gft_table.sv
module gft_table #(
  parameter int NUM_THREADS = 4,
  parameter int NUM_UPD     = 2,
  parameter int NUM_QRY     = 2,
  parameter int TS_W        = 8,
  parameter int TID_W       = gft_pkg::idx_w(NUM_THREADS)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_UPD-1:0]       upd_valid,
  input  logic [NUM_UPD*TID_W-1:0] upd_tid,
  input  logic [NUM_UPD*TS_W-1:0]  upd_ts,
  output logic [NUM_UPD-1:0]       upd_ready,
  input  logic [NUM_QRY-1:0]       qry_valid,
  input  logic [NUM_QRY*TID_W-1:0] qry_tid,
  input  logic [NUM_QRY*TS_W-1:0]  qry_ts,
  output logic [NUM_QRY-1:0]       qry_ready
);
  localparam int REC_BITS = NUM_THREADS * TS_W;

  logic [NUM_THREADS-1:0] wr_en;
  logic [REC_BITS-1:0]    wr_ts;
  logic [REC_BITS-1:0]    rec_q_all;
  logic [REC_BITS-1:0]    rec_eff_all;

  gft_upd_arb #(
    .NUM_THREADS(NUM_THREADS), .NUM_UPD(NUM_UPD), .TS_W(TS_W), .TID_W(TID_W)
  ) u_arb (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_tid(upd_tid), .upd_ts(upd_ts),
    .upd_ready(upd_ready), .wr_en(wr_en), .wr_ts(wr_ts)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_rec
    gft_record #(.TS_W(TS_W)) u_rec (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en[t]), .wr_ts(wr_ts[t*TS_W +: TS_W]),
      .rec_q(rec_q_all[t*TS_W +: TS_W]),
      .rec_eff(rec_eff_all[t*TS_W +: TS_W])
    );
  end

  for (genvar q = 0; q < NUM_QRY; q++) begin : g_qry
    gft_query #(
      .NUM_THREADS(NUM_THREADS), .TS_W(TS_W), .TID_W(TID_W)
    ) u_qry (
      .clk(clk), .rst_n(rst_n),
      .qry_valid(qry_valid[q]),
      .qry_tid(qry_tid[q*TID_W +: TID_W]),
      .qry_ts(qry_ts[q*TS_W +: TS_W]),
      .rec_eff_all(rec_eff_all),
      .qry_ready(qry_ready[q])
    );
  end

  // R7
  all_ready_when_distinct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(wr_en) == $countones(upd_valid)) |-> (upd_ready == {NUM_UPD{1'b1}}));
endmodule

// File: tb/gft_table_test.sv
module gft_table_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]  upd_valid = '0;
  logic [3:0]  upd_tid   = '0;
  logic [15:0] upd_ts    = '0;
  logic [1:0]  upd_ready;
  logic [1:0]  qry_valid = '0;
  logic [3:0]  qry_tid   = '0;
  logic [15:0] qry_ts    = '0;
  logic [1:0]  qry_ready;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  gft_table uut (
    .clk(clk), .rst_n(rst_n),
    .upd_valid(upd_valid), .upd_tid(upd_tid), .upd_ts(upd_ts), .upd_ready(upd_ready),
    .qry_valid(qry_valid), .qry_tid(qry_tid), .qry_ts(qry_ts), .qry_ready(qry_ready)
  );

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic idle();
    upd_valid = '0;
    qry_valid = '0;
  endtask

  task automatic upd(input int p, input int tid, input int ts);
    upd_valid[p]      = 1'b1;
    upd_tid[p*2 +: 2] = 2'(tid);
    upd_ts[p*8 +: 8]  = 8'(ts);
  endtask

  task automatic qry(input int p, input int tid, input int ts);
    qry_valid[p]      = 1'b1;
    qry_tid[p*2 +: 2] = 2'(tid);
    qry_ts[p*8 +: 8]  = 8'(ts);
  endtask

  // Drive at a falling edge, wait 2 ns, then sample the combinational outputs.
  task automatic settle();
    #2;
  endtask

  task automatic next_cycle();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    for (int t = 0; t < 4; t++) begin
      qry(0, t, 0); qry(1, t, 1); settle();
      chk("R1 zero req granted", qry_ready[0], 1'b1);
      chk("R1 req 1 stalled", qry_ready[1], 1'b0);
    end
    idle(); settle();
    chk("R9 idle port 0", qry_ready[0], 1'b0);
    chk("R9 idle port 1", qry_ready[1], 1'b0);
    next_cycle();
  endtask

  task automatic t_basic_and_bypass();
    upd(0, 0, 24); settle();
    chk("R3 update accepted", upd_ready[0], 1'b1);
    next_cycle();
    qry(0, 0, 25); qry(1, 0, 24); settle();
    chk("R2 24 vs 25 stalls", qry_ready[0], 1'b0);
    chk("R2 24 vs 24 granted", qry_ready[1], 1'b1);
    next_cycle();
    qry(1, 0, 25); settle();
    chk("R8 stalled before fence", qry_ready[1], 1'b0);
    next_cycle();
    qry(1, 0, 25); upd(0, 0, 25); settle();
    chk("R5 same-cycle bypass grant", qry_ready[1], 1'b1);
    next_cycle();
    qry(1, 0, 25); qry(0, 0, 23); settle();
    chk("R8 granted after fence", qry_ready[1], 1'b1);
    chk("R2 lower req granted", qry_ready[0], 1'b1);
    next_cycle();
  endtask

  task automatic t_ignore_small();
    upd(0, 0, 10); qry(0, 0, 25); settle();
    chk("R4 small update accepted", upd_ready[0], 1'b1);
    chk("R4 bypass keeps larger value", qry_ready[0], 1'b1);
    next_cycle();
    qry(0, 0, 25); qry(1, 0, 26); settle();
    chk("R4 record still 25", qry_ready[0], 1'b1);
    chk("R4 record not above 25", qry_ready[1], 1'b0);
    next_cycle();
  endtask

  task automatic t_conflict();
    upd(0, 2, 7); upd(1, 2, 9); qry(0, 2, 7); qry(1, 2, 8); settle();
    chk("R6 port 0 wins", upd_ready[0], 1'b1);
    chk("R6 port 1 refused", upd_ready[1], 1'b0);
    chk("R6 bypass winner 7", qry_ready[0], 1'b1);
    chk("R6 bypass not loser 9", qry_ready[1], 1'b0);
    next_cycle();
    qry(0, 2, 7); qry(1, 2, 8); settle();
    chk("R6 record 7 after edge", qry_ready[0], 1'b1);
    chk("R6 loser not written", qry_ready[1], 1'b0);
    next_cycle();
    upd(1, 2, 9); settle();
    chk("R6 retry accepted", upd_ready[1], 1'b1);
    next_cycle();
    qry(0, 2, 9); qry(1, 2, 10); settle();
    chk("R6 retry written", qry_ready[0], 1'b1);
    chk("R6 retry value exact", qry_ready[1], 1'b0);
    next_cycle();
  endtask

  task automatic t_parallel();
    upd(0, 1, 40); upd(1, 3, 50); settle();
    chk("R7 port 0 accepted", upd_ready[0], 1'b1);
    chk("R7 port 1 accepted", upd_ready[1], 1'b1);
    next_cycle();
    qry(0, 1, 40); qry(1, 3, 50); settle();
    chk("R7 thread 1 written", qry_ready[0], 1'b1);
    chk("R7 thread 3 written", qry_ready[1], 1'b1);
    next_cycle();
    qry(0, 1, 41); qry(1, 3, 51); settle();
    chk("R8 port 0 stall independent", qry_ready[0], 1'b0);
    chk("R8 port 1 stall independent", qry_ready[1], 1'b0);
    qry(1, 3, 50); settle();
    chk("R8 port 1 grant with port 0 stalled", qry_ready[1], 1'b1);
    next_cycle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    next_cycle();
    t_basic_and_bypass();
    t_ignore_small();
    t_conflict();
    t_parallel();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #400000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule